// File: doc/BRIEF.md
# Command/Response Ring Pointer Engine

This block is the hardware half of a circular command ring in a host controller. Software fills descriptor slots in memory and then publishes its progress by writing an enqueue index. The engine owns a hardware dequeue index. While it is allowed to run and work is outstanding, it asks the memory side for the descriptor at that index. A descriptor that is marked as a no-op is consumed on the spot. Any other descriptor starts a transfer and holds the engine until the bus engine posts a response. That response moves the hardware index forward and produces a completion or error event.

Software acknowledges the responses it has read by writing a separate software dequeue index. Comparing the three indices gives the pending-work, pending-response and ring-full indications. Every index wraps at a ring size that software programs. An abort request stops fetching. A single ring-operation event confirms the stop once no transfer is left in flight.

Top module: `crr_ring_engine`

## Requirements
- R1: After reset the control word reads 0, the ring size reads 255, both operation words read 0, and fetch_req, xfer_start, done_evt, err_evt, op_evt, work_pend, resp_pend and ring_full are all low.
- R2: The size word (address 1, bits 8:0) holds the ring length. A written value above 255 is stored as 255 and a value below 2 is stored as 2. A read returns the stored value.
- R3: Operation word A (address 2) holds the enqueue index in bits 7:0 and the software dequeue index in bits 15:8. Operation word B (address 3, bits 7:0) returns the hardware dequeue index and ignores writes. A field written with a value not below the ring size keeps its old value.
- R4: A write of all zeros to operation word A clears the enqueue, software dequeue and hardware dequeue indices.
- R5: work_pend is high when enqueue differs from hardware dequeue. resp_pend is high when software dequeue differs from hardware dequeue. ring_full is high when (enqueue+1) mod size equals hardware dequeue.
- R6: fetch_req is raised only while control bit 0 (enable) and bit 1 (run) are set, bit 2 (abort) is clear, and work is pending. fetch_slot equals the hardware dequeue index. fetch_req stays high until fetch_ack.
- R7: A descriptor acknowledged with fetch_attr equal to 7 advances the hardware dequeue index without a xfer_start pulse and without any event.
- R8: A descriptor acknowledged with any other attribute produces a one-cycle xfer_start whose xfer_len equals bits 15:0 of fetch_dbuf. The engine then waits for a response.
- R9: A response accepted while waiting advances the hardware dequeue index and pulses done_evt for one cycle, or err_evt instead when resp_err is set. The pulse carries done_tid equal to resp_tid and done_ioc equal to bit 30 of the descriptor's fetch_dbuf.
- R10: A resp_valid strobe while no transfer is in flight has no effect on indices or events.
- R11: Writing the abort bit from 0 to 1 stops further fetches. One op_evt pulse follows once no transfer is in flight. A transfer already started completes first.
- R12: The hardware dequeue index wraps from size-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_slot | output | 8 | Ring slot to fetch |
| fetch_ack | input | 1 | Descriptor delivered |
| fetch_attr | input | 3 | Attribute field of the descriptor |
| fetch_dbuf | input | 32 | Data-buffer word: bit 30 interrupt-on-completion, bits 15:0 length |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_len | output | 16 | Length of the started transfer |
| resp_valid | input | 1 | Response post strobe |
| resp_err | input | 1 | Response error flag |
| resp_tid | input | 4 | Response transaction ID |
| done_evt | output | 1 | Completion event pulse |
| err_evt | output | 1 | Transfer-error event pulse |
| done_ioc | output | 1 | Interrupt-on-completion flag of the finished slot |
| done_tid | output | 4 | Transaction ID of the finished slot |
| op_evt | output | 1 | Ring-operation (abort done) event pulse |
| work_pend | output | 1 | Descriptors outstanding |
| resp_pend | output | 1 | Responses not yet acknowledged |
| ring_full | output | 1 | Enqueue may not advance |

## Verification
The fetch path is tried with three kinds of descriptors mixed in one batch: plain transfers, transfers whose responses carry the error flag, and no-ops. This separates event routing from index advance. A batch that crosses the end of a four-slot ring shows whether wrap happens at the programmed size and not at the index width. The engine is aborted once with a slow response in flight and once while idle. This tells apart an event that waits for the transfer from one that fires at once. Stray responses and out-of-range index writes check that the indices stay untouched.

// File: rtl/crr_pkg.sv
package crr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_BUSY  = 2'd2
  } eng_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SIZE = 2'd1;
  localparam logic [1:0] ADDR_OPA  = 2'd2;
  localparam logic [1:0] ADDR_OPB  = 2'd3;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_RUN   = 1;
  localparam int CTRL_ABORT = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/crr_rst_sync.sv
module crr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/crr_ptr_inc.sv
module crr_ptr_inc #(
  parameter int PTR_W  = 8,
  parameter int SIZE_W = 9
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [SIZE_W-1:0] size,
  output logic [PTR_W-1:0]  nxt
);
  logic [SIZE_W-1:0] ext;

  always_comb begin
    ext = SIZE_W'(ptr) + SIZE_W'(1);
    nxt = (ext >= size) ? '0 : ext[PTR_W-1:0];
  end
endmodule

// File: rtl/crr_regs.sv
module crr_regs
  import crr_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SIZE_W      = 9,
  parameter int MAX_ENTRIES = 255,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PTR_W-1:0]  hw_deq,
  output logic              ctrl_en,
  output logic              ctrl_run,
  output logic              ctrl_abort,
  output logic              abort_set,
  output logic              ptr_zero,
  output logic [SIZE_W-1:0] ring_size,
  output logic [PTR_W-1:0]  enq_ptr,
  output logic [PTR_W-1:0]  sw_deq,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(MAX_ENTRIES);
  localparam logic [SIZE_W-1:0] SZ_MIN = SIZE_W'(2);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [SIZE_W-1:0] size_q, size_d, size_req;
  logic [PTR_W-1:0]  enq_q, enq_d, sw_q, sw_d, enq_req, sw_req;
  logic              wr_ctrl, wr_size, wr_opa;
  logic              unused_wdata;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_size  = reg_wr && (reg_addr == ADDR_SIZE);
  assign wr_opa   = reg_wr && (reg_addr == ADDR_OPA);
  assign size_req = reg_wdata[SIZE_W-1:0];
  assign enq_req  = reg_wdata[PTR_W-1:0];
  assign sw_req   = reg_wdata[2*PTR_W-1:PTR_W];
  assign unused_wdata = ^reg_wdata;

  // next-state
  always_comb begin
    ctrl_d = reg_wdata[CTRL_W-1:0];
    if (size_req > SZ_MAX)      size_d = SZ_MAX;
    else if (size_req < SZ_MIN) size_d = SZ_MIN;
    else                        size_d = size_req;
    enq_d = (SIZE_W'(enq_req) < size_q) ? enq_req : enq_q;
    sw_d  = (SIZE_W'(sw_req)  < size_q) ? sw_req  : sw_q;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= SZ_MAX;
      enq_q  <= '0;
      sw_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_size) size_q <= size_d;
      if (wr_opa) begin
        enq_q <= enq_d;
        sw_q  <= sw_d;
      end
    end
  end

  assign ctrl_en    = ctrl_q[CTRL_EN];
  assign ctrl_run   = ctrl_q[CTRL_RUN];
  assign ctrl_abort = ctrl_q[CTRL_ABORT];
  assign abort_set  = wr_ctrl && reg_wdata[CTRL_ABORT] && !ctrl_q[CTRL_ABORT];
  assign ptr_zero   = wr_opa && (reg_wdata == '0);
  assign ring_size  = size_q;
  assign enq_ptr    = enq_q;
  assign sw_deq     = sw_q;

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'(ctrl_q);
      ADDR_SIZE: reg_rdata = DATA_W'(size_q);
      ADDR_OPA:  reg_rdata = DATA_W'({sw_q, enq_q});
      default:   reg_rdata = DATA_W'(hw_deq);
    endcase
  end
endmodule

// File: rtl/crr_fetch_fsm.sv
module crr_fetch_fsm
  import crr_pkg::*;
#(
  parameter int PTR_W     = 8,
  parameter int ATTR_W    = 3,
  parameter int NOOP_ATTR = 7,
  parameter int DBUF_W    = 32,
  parameter int IOC_BIT   = 30,
  parameter int LEN_W     = 16,
  parameter int TID_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_go,
  input  logic              work_pend,
  input  logic              abort_set,
  input  logic              ptr_zero,
  input  logic [PTR_W-1:0]  deq_inc,
  input  logic              fetch_ack,
  input  logic [ATTR_W-1:0] fetch_attr,
  input  logic [DBUF_W-1:0] fetch_dbuf,
  input  logic              resp_valid,
  input  logic              resp_err,
  input  logic [TID_W-1:0]  resp_tid,
  output logic [PTR_W-1:0]  hw_deq,
  output logic              fetch_req,
  output logic              xfer_start,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              done_evt,
  output logic              err_evt,
  output logic              done_ioc,
  output logic [TID_W-1:0]  done_tid,
  output logic              op_evt
);
  localparam logic [ATTR_W-1:0] NOOP = ATTR_W'(NOOP_ATTR);

  eng_state_e        state_q, state_d;
  logic [PTR_W-1:0]  deq_q, deq_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [TID_W-1:0]  tid_q, tid_d;
  logic              ioc_q, ioc_d, dioc_q, dioc_d;
  logic              start_q, start_d, done_q, done_d, err_q, err_d;
  logic              apend_q, apend_d, op_q, op_d;
  logic              unused_dbuf;

  assign unused_dbuf = ^fetch_dbuf;

  always_comb begin
    state_d = state_q;
    deq_d   = deq_q;
    len_d   = len_q;
    tid_d   = tid_q;
    ioc_d   = ioc_q;
    dioc_d  = dioc_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    op_d    = 1'b0;
    apend_d = apend_q | abort_set;
    unique case (state_q)
      ST_IDLE: if (ring_go && work_pend) state_d = ST_FETCH;
      ST_FETCH: begin
        if (fetch_ack) begin
          if (fetch_attr == NOOP) begin
            deq_d   = deq_inc;
            state_d = ST_IDLE;
          end else begin
            ioc_d   = fetch_dbuf[IOC_BIT];
            len_d   = fetch_dbuf[LEN_W-1:0];
            start_d = 1'b1;
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (resp_valid) begin
          deq_d   = deq_inc;
          done_d  = !resp_err;
          err_d   = resp_err;
          tid_d   = resp_tid;
          dioc_d  = ioc_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (apend_q && (state_q == ST_IDLE)) begin
      op_d    = 1'b1;
      apend_d = abort_set;
    end
    if (ptr_zero) deq_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      deq_q   <= '0;
      len_q   <= '0;
      tid_q   <= '0;
      ioc_q   <= 1'b0;
      dioc_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      apend_q <= 1'b0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      deq_q   <= deq_d;
      start_q <= start_d;
      done_q  <= done_d;
      err_q   <= err_d;
      apend_q <= apend_d;
      op_q    <= op_d;
      if (start_d) begin
        len_q <= len_d;
        ioc_q <= ioc_d;
      end
      if (done_d || err_d) begin
        tid_q  <= tid_d;
        dioc_q <= dioc_d;
      end
    end
  end

  assign hw_deq     = deq_q;
  assign fetch_req  = (state_q == ST_FETCH);
  assign xfer_start = start_q;
  assign xfer_len   = len_q;
  assign done_evt   = done_q;
  assign err_evt    = err_q;
  assign done_ioc   = dioc_q;
  assign done_tid   = tid_q;
  assign op_evt     = op_q;
endmodule

// File: rtl/crr_ring_engine.sv
module crr_ring_engine
  import crr_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SIZE_W      = 9,
  parameter int MAX_ENTRIES = 255,
  parameter int DATA_W      = 32,
  parameter int ATTR_W      = 3,
  parameter int NOOP_ATTR   = 7,
  parameter int IOC_BIT     = 30,
  parameter int LEN_W       = 16,
  parameter int TID_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fetch_req,
  output logic [PTR_W-1:0]  fetch_slot,
  input  logic              fetch_ack,
  input  logic [ATTR_W-1:0] fetch_attr,
  input  logic [DATA_W-1:0] fetch_dbuf,
  output logic              xfer_start,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              resp_valid,
  input  logic              resp_err,
  input  logic [TID_W-1:0]  resp_tid,
  output logic              done_evt,
  output logic              err_evt,
  output logic              done_ioc,
  output logic [TID_W-1:0]  done_tid,
  output logic              op_evt,
  output logic              work_pend,
  output logic              resp_pend,
  output logic              ring_full
);
  localparam int N_INC = 2;   // 0: enqueue (full test), 1: hardware dequeue

  logic              rst_n_s;
  logic              ctrl_en, ctrl_run, ctrl_abort, abort_set, ptr_zero, ring_go;
  logic [SIZE_W-1:0] ring_size;
  logic [PTR_W-1:0]  enq_ptr, sw_deq, hw_deq;
  logic [PTR_W-1:0]  inc_src [N_INC];
  logic [PTR_W-1:0]  inc_res [N_INC];

  crr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  crr_regs #(
    .PTR_W(PTR_W), .SIZE_W(SIZE_W), .MAX_ENTRIES(MAX_ENTRIES), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .hw_deq(hw_deq), .ctrl_en(ctrl_en),
    .ctrl_run(ctrl_run), .ctrl_abort(ctrl_abort), .abort_set(abort_set),
    .ptr_zero(ptr_zero), .ring_size(ring_size), .enq_ptr(enq_ptr),
    .sw_deq(sw_deq), .reg_rdata(reg_rdata)
  );

  assign inc_src[0] = enq_ptr;
  assign inc_src[1] = hw_deq;

  for (genvar gi = 0; gi < N_INC; gi++) begin : g_inc
    crr_ptr_inc #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) u_inc (
      .ptr(inc_src[gi]), .size(ring_size), .nxt(inc_res[gi])
    );
  end

  assign ring_go   = ctrl_en && ctrl_run && !ctrl_abort;
  assign work_pend = (enq_ptr != hw_deq);
  assign resp_pend = (sw_deq != hw_deq);
  assign ring_full = (inc_res[0] == hw_deq);

  crr_fetch_fsm #(
    .PTR_W(PTR_W), .ATTR_W(ATTR_W), .NOOP_ATTR(NOOP_ATTR), .DBUF_W(DATA_W),
    .IOC_BIT(IOC_BIT), .LEN_W(LEN_W), .TID_W(TID_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .ring_go(ring_go), .work_pend(work_pend),
    .abort_set(abort_set), .ptr_zero(ptr_zero), .deq_inc(inc_res[1]),
    .fetch_ack(fetch_ack), .fetch_attr(fetch_attr), .fetch_dbuf(fetch_dbuf),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_tid(resp_tid),
    .hw_deq(hw_deq), .fetch_req(fetch_req), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .done_evt(done_evt), .err_evt(err_evt),
    .done_ioc(done_ioc), .done_tid(done_tid), .op_evt(op_evt)
  );

  assign fetch_slot = hw_deq;
endmodule

// File: rtl/crr_ring_engine_chk.sv
module crr_ring_engine_chk #(
  parameter int ATTR_W = 3
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              ring_go,
  input logic              work_pend,
  input logic              fetch_req,
  input logic              fetch_ack,
  input logic [ATTR_W-1:0] fetch_attr,
  input logic              xfer_start,
  input logic              resp_valid,
  input logic              done_evt,
  input logic              err_evt,
  input logic              op_evt
);
  // R6: a new request needs an enabled, running, unaborted ring with work
  a_r6_req_gated: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(fetch_req) |-> $past(ring_go && work_pend));

  // R6: request is held until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fetch_req && !fetch_ack) |=> fetch_req);

  // R7: a no-op never starts a transfer
  a_r7_noop_silent: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fetch_req && fetch_ack && (fetch_attr == ATTR_W'(7))) |=> !xfer_start);

  // R8: a transfer starts only from an acknowledged fetch
  a_r8_start_from_ack: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer_start |-> $past(fetch_req && fetch_ack));

  // R9: completion and error are exclusive
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(done_evt && err_evt));

  // R10: every event follows a response strobe
  a_r10_event_needs_resp: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done_evt || err_evt) |-> $past(resp_valid));

  // R11: no ring-operation event right after a transfer started
  a_r11_op_not_in_flight: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(xfer_start) |-> !op_evt);
endmodule

bind crr_ring_engine crr_ring_engine_chk #(.ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .ring_go(ring_go), .work_pend(work_pend),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_attr(fetch_attr),
  .xfer_start(xfer_start), .resp_valid(resp_valid), .done_evt(done_evt),
  .err_evt(err_evt), .op_evt(op_evt)
);

// File: tb/crr_ring_engine_tb_top.sv
`timescale 1ns/1ps
module crr_ring_engine_tb_top;
  typedef struct packed {
    logic       err;
    logic       ioc;
    logic [3:0] tid;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        fetch_req, fetch_ack;
  logic [7:0]  fetch_slot;
  logic [2:0]  fetch_attr;
  logic [31:0] fetch_dbuf;
  logic        xfer_start;
  logic [15:0] xfer_len;
  logic        resp_v, stray_v, resp_valid, resp_err;
  logic [3:0]  resp_tid, done_tid;
  logic        done_evt, err_evt, done_ioc, op_evt;
  logic        work_pend, resp_pend, ring_full;

  logic [2:0]  attr_m [256];
  logic        err_m  [256];
  logic        ioc_m  [256];
  exp_t        exp_q [$];

  int n_chk = 0, n_fail = 0;
  int mon_chk = 0, mon_fail = 0, rsp_chk = 0, rsp_fail = 0;
  int wd_fail = 0;
  int cyc = 0, done_cyc = 0, op_cyc = 0, op_cnt = 0, ev_cnt = 0, req_cnt = 0;
  int start_cnt = 0, resp_delay = 2, rv_cnt = 0, cur_slot = 0;
  int tb_enq = 0, tb_sw = 0, tb_size = 255;

  always #4 clk = ~clk;

  assign resp_valid = resp_v | stray_v;

  crr_ring_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_slot(fetch_slot), .fetch_ack(fetch_ack), .fetch_attr(fetch_attr),
    .fetch_dbuf(fetch_dbuf), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_tid(resp_tid),
    .done_evt(done_evt), .err_evt(err_evt), .done_ioc(done_ioc),
    .done_tid(done_tid), .op_evt(op_evt), .work_pend(work_pend),
    .resp_pend(resp_pend), .ring_full(ring_full)
  );

  function automatic logic [3:0] tid_f(input int s);
    return 4'(s) ^ 4'hA;
  endfunction

  function automatic logic [15:0] len_f(input int s);
    return 16'(s * 3 + 7);
  endfunction

  // memory-side responder: fetch acknowledge and delayed responses
  always @(negedge clk) begin
    if (!rst_n) begin
      fetch_ack = 1'b0; resp_v = 1'b0; rv_cnt = 0;
    end else begin
      resp_v = 1'b0;
      if (fetch_ack) fetch_ack = 1'b0;
      else if (fetch_req) begin
        fetch_ack  = 1'b1;
        fetch_attr = attr_m[fetch_slot];
        fetch_dbuf = {1'b0, ioc_m[fetch_slot], 14'd0, len_f(int'(fetch_slot))};
      end
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin
          resp_v   = 1'b1;
          resp_err = err_m[cur_slot];
          resp_tid = tid_f(cur_slot);
        end
      end
      if (xfer_start) begin
        start_cnt++;
        rsp_chk++;
        if (xfer_len !== len_f(int'(fetch_slot))) begin
          rsp_fail++;
          $display("FAIL R8: xfer_len actual %0h expected %0h", xfer_len, len_f(int'(fetch_slot)));
        end
        cur_slot = int'(fetch_slot);
        rv_cnt   = resp_delay;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (fetch_req) req_cnt++;
    if (op_evt) begin op_cnt++; op_cyc = cyc; end
    if (done_evt || err_evt) begin
      ev_cnt++;
      done_cyc = cyc;
      mon_chk++;
      if (exp_q.size() == 0) begin
        mon_fail++;
        $display("FAIL R9: unexpected event actual tid %0h expected none", done_tid);
      end else begin
        e = exp_q.pop_front();
        if ({err_evt, done_evt, done_ioc, done_tid} !== {e.err, !e.err, e.ioc, e.tid}) begin
          mon_fail++;
          $display("FAIL R9: event actual err=%0b ioc=%0b tid=%0h expected err=%0b ioc=%0b tid=%0h",
                   err_evt, done_ioc, done_tid, e.err, e.ioc, e.tid);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic post_enq(input int v);
    int s = tb_enq;
    while (s != v) begin
      if (attr_m[s] != 3'd7) exp_q.push_back(exp_t'({err_m[s], ioc_m[s], tid_f(s)}));
      s = (s + 1) % tb_size;
    end
    tb_enq = v;
    wr(2'd2, {16'd0, 8'(tb_sw), 8'(v)});
  endtask

  task automatic wait_deq(input string req, input int v);
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, d);
      if (d[7:0] == 8'(v)) break;
    end
    chk(req, d, 32'(v));
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    int tot, bad;
    tot = n_chk + mon_chk + rsp_chk + wd_fail;
    bad = n_fail + mon_fail + rsp_fail + wd_fail;
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0;
    for (int i = 0; i < 256; i++) begin
      attr_m[i] = 3'd0; err_m[i] = 1'b0; ioc_m[i] = i[0];
    end
    attr_m[1] = 3'd7;
    err_m[2]  = 1'b1;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    stray_v = 1'b0; resp_err = 1'b0; resp_tid = '0;
    fetch_attr = '0; fetch_dbuf = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
    rd(2'd1, d); chk("R1 size", d, 32'd255);
    rd(2'd2, d); chk("R1 opA", d, 32'd0);
    rd(2'd3, d); chk("R1 opB", d, 32'd0);
    chk("R1 outputs", {fetch_req, xfer_start, done_evt, err_evt, op_evt, work_pend, resp_pend, ring_full}, 0);

    // R2 size clamping
    wr(2'd1, 32'd300); rd(2'd1, d); chk("R2 clamp high", d, 32'd255);
    wr(2'd1, 32'd1);   rd(2'd1, d); chk("R2 clamp low", d, 32'd2);
    wr(2'd1, 32'd4);   rd(2'd1, d); chk("R2 size 4", d, 32'd4);
    tb_size = 4;

    // stopped ring: R3 layout, R5 status, R6 gating
    post_enq(3);
    rd(2'd2, d); chk("R3 enq field", d, 32'h0003);
    chk("R5 work_pend", 32'(work_pend), 1);
    chk("R5 ring_full", 32'(ring_full), 1);
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, d); chk("R3 enq out of range ignored", d, 32'h0003);
    wr(2'd3, 32'd2);
    rd(2'd3, d); chk("R3 opB write ignored", d, 32'd0);
    wr(2'd0, 32'd1);
    repeat (10) @(negedge clk);
    chk("R6 no fetch without run", 32'(req_cnt), 0);

    // run: slot0 ok, slot1 no-op, slot2 error
    wr(2'd0, 32'd3);
    wait_deq("R9 deq after batch", 3);
    chk("R7 no-op starts nothing", 32'(start_cnt), 2);
    chk("R5 status after batch", {29'd0, work_pend, resp_pend, ring_full}, 32'b010);

    // R12 wrap: slots 3 then 0
    post_enq(1);
    wait_deq("R12 wrap", 1);
    tb_sw = 1;
    wr(2'd2, 32'h0101);
    chk("R5 resp_pend cleared", 32'(resp_pend), 0);

    // R10 stray response
    s0 = ev_cnt;
    @(negedge clk); stray_v = 1'b1;
    @(negedge clk); stray_v = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 no event", 32'(ev_cnt), 32'(s0));
    rd(2'd3, d); chk("R10 deq unchanged", d, 32'd1);

    // R11 abort with a transfer in flight
    resp_delay = 8;
    s0 = start_cnt;
    post_enq(0);
    for (int i = 0; i < 100 && start_cnt == s0; i++) @(negedge clk);
    wr(2'd0, 32'd7);
    repeat (30) @(negedge clk);
    chk("R11 one op event", 32'(op_cnt), 1);
    chk("R11 op after in-flight done", 32'(op_cyc > done_cyc), 1);
    rd(2'd3, d); chk("R11 fetch stopped", d, 32'd3);
    chk("R11 work left", 32'(work_pend), 1);

    // R11 abort while idle
    wr(2'd0, 32'd0);
    wr(2'd0, 32'd4);
    repeat (5) @(negedge clk);
    chk("R11 idle abort event", 32'(op_cnt), 2);

    // resume and drain, slot 3 then wrap to 0
    resp_delay = 2;
    wr(2'd0, 32'd3);
    wait_deq("R12 wrap to zero", 0);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 0);

    // R4 zero write
    wr(2'd0, 32'd0);
    post_enq(2);
    wr(2'd2, 32'd0);
    tb_enq = 0; tb_sw = 0;
    rd(2'd2, d); chk("R4 opA cleared", d, 32'd0);
    rd(2'd3, d); chk("R4 opB", d, 32'd0);
    chk("R4 status", {30'd0, work_pend, resp_pend}, 0);
    exp_q.delete();

    summary();
    $finish;
  end
endmodule